// File: doc/BRIEF.md
# Instruction Prefetch Window Buffer

This block keeps a small, contiguous window of instruction bytes, WIN_BYTES long, taken from linear memory. It sits between an instruction decoder and a memory read port that is one or two bytes wide. For each fetch request it chooses one of four outcomes. It can serve the bytes from the window it already holds. It can refill the window with a burst and then serve from the new window. It can read the requested bytes straight from memory, bypassing the window. Or it can drop the window and then read directly. The choice depends on the segment offset and limit, on the paging-enable bit, and on whether the request would run past a clamped window near a page boundary.

A fetch is accepted only while `busy` is low. It completes with a one-cycle `done` pulse, which carries the fetched bytes and two flags: `bypass` for a direct read and `fault` for a failed memory read. Data writes seen on the snoop port patch the buffered bytes, so the window stays consistent with memory. A context-switch flush input discards the window.

Top module: `prefetch_window`

## Requirements
- R1: After reset, `busy`, `done` and `win_valid` are all low.
- R2: When fetch_offset + WIN_BYTES - 1 exceeds fetch_limit, the fetch is served by a direct memory read. `bypass` is high with `done`, and the window's valid state and start are left unchanged.
- R3: With paging on and a page offset of the fetch address greater than PAGE_BYTES - WIN_BYTES, a refill starts at the page base ORed with PAGE_BYTES - WIN_BYTES. Without that condition, a refill starts at the fetch address.
- R4: When the window start is clamped and (fetch address - start + size) is at least WIN_BYTES, the window is invalidated and the fetch is read directly, with `bypass` high.
- R5: A request whose whole byte range lies inside a valid window is served without any memory read. `done` rises at the first sampling point after the accepting edge.
- R6: A refill reads WIN_BYTES / BUS_BYTES beats at consecutive addresses, sets `win_valid`, and returns the bytes found at index (fetch address - window start).
- R7: A memory error during a refill ends the fetch with `fault` high, `bypass` low and `win_valid` low.
- R8: A snooped write whose range lies fully inside a valid window overwrites the matching buffered bytes, so later window hits return the written values.
- R9: `ctx_flush` clears `win_valid` by the next cycle, and the next fetch refills.
- R10: `done` is a single pulse while `busy` is low. Memory is read only while `busy` is high. A request raised while `busy` is high is ignored.
- R11: In `fetch_data`, byte i (bits 8i+7..8i) holds the byte at fetch address + i for i < size. All higher bytes are zero.
- R12: A direct read takes ceil(size / BUS_BYTES) beats starting at the fetch address. A memory error during a direct read raises `fault` and `bypass` and leaves `win_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request, sampled while not busy |
| fetch_addr | input | ADDR_W | Linear address of the first byte |
| fetch_offset | input | ADDR_W | Segment offset of the first byte |
| fetch_limit | input | ADDR_W | Segment limit |
| fetch_size | input | clog2(MAX_FETCH+1) | Byte count, 1..MAX_FETCH |
| paging_on | input | 1 | Paging enabled |
| snoop_we | input | 1 | Data write observed |
| snoop_addr | input | ADDR_W | Linear address of the write |
| snoop_size | input | clog2(MAX_FETCH+1) | Bytes written |
| snoop_data | input | 8*MAX_FETCH | Write bytes, lowest address in bits 7..0 |
| ctx_flush | input | 1 | Discard the window (context switch) |
| mem_rd_en | output | 1 | Memory read beat requested |
| mem_addr | output | ADDR_W | Address of the beat's first byte |
| mem_rdata | input | 8*BUS_BYTES | Beat data |
| mem_rd_ack | input | 1 | Beat completed |
| mem_rd_err | input | 1 | Beat failed (valid with ack) |
| busy | output | 1 | Refill or direct read in progress |
| done | output | 1 | Fetch result valid (one cycle) |
| fetch_data | output | 8*MAX_FETCH | Fetched bytes |
| bypass | output | 1 | Result came from a direct read |
| fault | output | 1 | Result ended by a memory error |
| win_valid | output | 1 | Window holds valid bytes |

## Verification
The assertions rely on a few conditions on the inputs. `fetch_size` and `snoop_size` lie between 1 and MAX_FETCH, and MAX_FETCH is below WIN_BYTES. Memory keeps `mem_addr` stable until it acknowledges, and snooped writes never arrive in the middle of a refill. The stimulus keeps to these conditions in three ways. Sizes are drawn only from 1 to 4. The memory model acknowledges every beat in the cycle it is requested. Writes and flushes are issued only between fetches, after `done` has been seen. The one exception is a request deliberately raised while busy.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_DIRECT = 2'd2,
        ST_SERVE  = 2'd3
    } pfw_state_e;

    typedef enum logic [1:0] {
        ACT_HIT    = 2'd0,
        ACT_FILL   = 2'd1,
        ACT_DIRECT = 2'd2,
        ACT_SPILL  = 2'd3
    } pfw_action_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/pfw_decide.sv
module pfw_decide
    import pfw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int WIN_BYTES  = 16,
    parameter int MAX_FETCH  = 4
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [ADDR_W-1:0]                  offset,
    input  logic [ADDR_W-1:0]                  limit,
    input  logic [$clog2(MAX_FETCH+1)-1:0]     size,
    input  logic                               paging,
    input  logic                               win_valid,
    input  logic [ADDR_W-1:0]                  win_start,
    output pfw_action_e                        action,
    output logic [ADDR_W-1:0]                  fill_start
);
    localparam int PAGE_LG = $clog2(PAGE_BYTES);
    localparam int EW      = ADDR_W + 1;

    logic [EW-1:0]      lim_sum;
    logic               lim_ok;
    logic               clamp;
    logic [ADDR_W-1:0]  clamp_start;
    logic [ADDR_W-1:0]  rel;
    logic               spill;
    logic               hit;

    always_comb begin
        lim_sum     = {1'b0, offset} + EW'(WIN_BYTES - 1);
        lim_ok      = lim_sum <= {1'b0, limit};
        clamp       = paging && (addr[PAGE_LG-1:0] > PAGE_LG'(PAGE_BYTES - WIN_BYTES));
        clamp_start = {addr[ADDR_W-1:PAGE_LG], PAGE_LG'(PAGE_BYTES - WIN_BYTES)};
        fill_start  = clamp ? clamp_start : addr;
        rel         = addr - fill_start;
        spill       = clamp && (({1'b0, rel} + EW'(size)) >= EW'(WIN_BYTES));
        hit         = win_valid && (addr >= win_start) &&
                      (({1'b0, addr} + EW'(size)) <= ({1'b0, win_start} + EW'(WIN_BYTES)));
        if (!lim_ok)     action = ACT_DIRECT;
        else if (spill)  action = ACT_SPILL;
        else if (hit)    action = ACT_HIT;
        else             action = ACT_FILL;
    end
endmodule

// File: rtl/pfw_store.sv
module pfw_store #(
    parameter int WIN_BYTES = 16,
    parameter int BUS_BYTES = 2,
    parameter int MAX_FETCH = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               fill_we,
    input  logic [$clog2(WIN_BYTES)-1:0]       fill_idx,
    input  logic [8*BUS_BYTES-1:0]             fill_data,
    input  logic                               snp_we,
    input  logic [$clog2(WIN_BYTES)-1:0]       snp_idx,
    input  logic [$clog2(MAX_FETCH+1)-1:0]     snp_size,
    input  logic [8*MAX_FETCH-1:0]             snp_data,
    output logic [8*WIN_BYTES-1:0]             bytes_flat
);
    localparam int WIN_LG = $clog2(WIN_BYTES);

    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
        logic [7:0]        q;
        logic [WIN_LG-1:0] fo;
        logic [WIN_LG-1:0] so;
        logic              in_fill;
        logic              in_snp;

        always_comb begin
            fo      = WIN_LG'(b) - fill_idx;
            so      = WIN_LG'(b) - snp_idx;
            in_fill = fill_we && (int'(fo) < BUS_BYTES);
            in_snp  = snp_we && (int'(so) < int'(snp_size));
        end

        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (in_snp)
                q <= snp_data[int'(so)*8 +: 8];
            else if (in_fill)
                q <= fill_data[int'(fo)*8 +: 8];
        end

        assign bytes_flat[b*8 +: 8] = q;
    end
endmodule

// File: rtl/pfw_seq.sv
module pfw_seq
    import pfw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 16,
    parameter int BUS_BYTES = 2,
    parameter int MAX_FETCH = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic [$clog2(MAX_FETCH+1)-1:0]     req_size,
    input  pfw_action_e                        action,
    input  logic [ADDR_W-1:0]                  fill_start,
    input  logic                               flush,
    input  logic                               rd_ack,
    input  logic                               rd_err,
    input  logic [8*BUS_BYTES-1:0]             rd_data,
    input  logic [8*WIN_BYTES-1:0]             bytes_flat,
    output logic                               busy,
    output logic                               rd_en,
    output logic [ADDR_W-1:0]                  rd_addr,
    output logic                               fill_we,
    output logic [$clog2(WIN_BYTES)-1:0]       fill_idx,
    output logic                               win_valid,
    output logic [ADDR_W-1:0]                  win_start,
    output logic                               done,
    output logic                               bypass,
    output logic                               fault,
    output logic [8*MAX_FETCH-1:0]             data
);
    localparam int WIN_LG     = $clog2(WIN_BYTES);
    localparam int SZ_W       = $clog2(MAX_FETCH + 1);
    localparam int FILL_BEATS = WIN_BYTES / BUS_BYTES;
    localparam int CNT_W      = $clog2(FILL_BEATS + 1);

    pfw_state_e         state;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [SZ_W-1:0]    size_q;
    logic               kill;
    logic               fill_last;
    logic               dir_last;
    logic [ADDR_W-1:0]  hit_rel;
    logic [ADDR_W-1:0]  srv_rel;

    function automatic logic [8*MAX_FETCH-1:0] pick(
        input logic [8*WIN_BYTES-1:0] src,
        input logic [WIN_LG-1:0]      idx,
        input logic [SZ_W-1:0]        n
    );
        logic [8*MAX_FETCH-1:0] r;
        r = '0;
        for (int i = 0; i < MAX_FETCH; i++) begin
            logic [WIN_LG-1:0] k;
            k = idx + WIN_LG'(i);
            if (SZ_W'(i) < n)
                r[i*8 +: 8] = src[int'(k)*8 +: 8];
        end
        return r;
    endfunction

    always_comb begin
        busy      = (state != ST_IDLE);
        rd_en     = (state == ST_FILL) || (state == ST_DIRECT);
        rd_addr   = ((state == ST_FILL) ? base_q : addr_q) +
                    ADDR_W'(cnt) * ADDR_W'(BUS_BYTES);
        fill_we   = (state == ST_FILL) && rd_ack && !rd_err;
        fill_idx  = WIN_LG'(cnt) * WIN_LG'(BUS_BYTES);
        fill_last = (int'(cnt) == FILL_BEATS - 1);
        dir_last  = ((int'(cnt) + 1) * BUS_BYTES) >= int'(size_q);
        hit_rel   = req_addr - win_start;
        srv_rel   = addr_q - win_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            base_q    <= '0;
            addr_q    <= '0;
            size_q    <= '0;
            kill      <= 1'b0;
            win_valid <= 1'b0;
            win_start <= '0;
            done      <= 1'b0;
            bypass    <= 1'b0;
            fault     <= 1'b0;
            data      <= '0;
        end else begin
            done   <= 1'b0;
            bypass <= 1'b0;
            fault  <= 1'b0;
            if (flush) begin
                win_valid <= 1'b0;
                if (state == ST_FILL)
                    kill <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        addr_q <= req_addr;
                        size_q <= req_size;
                        cnt    <= '0;
                        kill   <= 1'b0;
                        unique case (action)
                            ACT_HIT: begin
                                data <= pick(bytes_flat, hit_rel[WIN_LG-1:0], req_size);
                                done <= 1'b1;
                            end
                            ACT_FILL: begin
                                base_q    <= fill_start;
                                win_valid <= 1'b0;
                                state     <= ST_FILL;
                            end
                            ACT_SPILL: begin
                                win_valid <= 1'b0;
                                data      <= '0;
                                state     <= ST_DIRECT;
                            end
                            ACT_DIRECT: begin
                                data  <= '0;
                                state <= ST_DIRECT;
                            end
                        endcase
                    end
                end
                ST_FILL: begin
                    if (rd_ack) begin
                        if (rd_err) begin
                            fault     <= 1'b1;
                            done      <= 1'b1;
                            win_valid <= 1'b0;
                            state     <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                            if (fill_last) begin
                                win_start <= base_q;
                                win_valid <= !(kill || flush);
                                state     <= ST_SERVE;
                            end
                        end
                    end
                end
                ST_SERVE: begin
                    data  <= pick(bytes_flat, srv_rel[WIN_LG-1:0], size_q);
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                ST_DIRECT: begin
                    if (rd_ack) begin
                        if (rd_err) begin
                            fault  <= 1'b1;
                            bypass <= 1'b1;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            for (int j = 0; j < BUS_BYTES; j++) begin
                                if ((int'(cnt) * BUS_BYTES + j) < int'(size_q))
                                    data[(int'(cnt) * BUS_BYTES + j)*8 +: 8] <= rd_data[j*8 +: 8];
                            end
                            cnt <= cnt + 1'b1;
                            if (dir_last) begin
                                bypass <= 1'b1;
                                done   <= 1'b1;
                                state  <= ST_IDLE;
                            end
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/prefetch_window.sv
module prefetch_window
    import pfw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int WIN_BYTES  = 16,
    parameter int BUS_BYTES  = 2,
    parameter int MAX_FETCH  = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               fetch_req,
    input  logic [ADDR_W-1:0]                  fetch_addr,
    input  logic [ADDR_W-1:0]                  fetch_offset,
    input  logic [ADDR_W-1:0]                  fetch_limit,
    input  logic [$clog2(MAX_FETCH+1)-1:0]     fetch_size,
    input  logic                               paging_on,
    input  logic                               snoop_we,
    input  logic [ADDR_W-1:0]                  snoop_addr,
    input  logic [$clog2(MAX_FETCH+1)-1:0]     snoop_size,
    input  logic [8*MAX_FETCH-1:0]             snoop_data,
    input  logic                               ctx_flush,
    output logic                               mem_rd_en,
    output logic [ADDR_W-1:0]                  mem_addr,
    input  logic [8*BUS_BYTES-1:0]             mem_rdata,
    input  logic                               mem_rd_ack,
    input  logic                               mem_rd_err,
    output logic                               busy,
    output logic                               done,
    output logic [8*MAX_FETCH-1:0]             fetch_data,
    output logic                               bypass,
    output logic                               fault,
    output logic                               win_valid
);
    localparam int WIN_LG = $clog2(WIN_BYTES);
    localparam int EW     = ADDR_W + 1;

    pfw_action_e         action;
    logic [ADDR_W-1:0]   fill_start;
    logic [ADDR_W-1:0]   win_start;
    logic                fill_we;
    logic [WIN_LG-1:0]   fill_idx;
    logic [8*WIN_BYTES-1:0] bytes_flat;
    logic                snp_hit;
    logic [ADDR_W-1:0]   snp_rel;

    always_comb begin
        snp_rel = snoop_addr - win_start;
        snp_hit = snoop_we && win_valid && (snoop_addr >= win_start) &&
                  (({1'b0, snoop_addr} + EW'(snoop_size)) <=
                   ({1'b0, win_start} + EW'(WIN_BYTES)));
    end

    pfw_decide #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
        .WIN_BYTES(WIN_BYTES), .MAX_FETCH(MAX_FETCH)
    ) u_decide (
        .addr(fetch_addr), .offset(fetch_offset), .limit(fetch_limit),
        .size(fetch_size), .paging(paging_on), .win_valid(win_valid),
        .win_start(win_start), .action(action), .fill_start(fill_start)
    );

    pfw_store #(
        .WIN_BYTES(WIN_BYTES), .BUS_BYTES(BUS_BYTES), .MAX_FETCH(MAX_FETCH)
    ) u_store (
        .clk(clk), .rst(rst), .fill_we(fill_we), .fill_idx(fill_idx),
        .fill_data(mem_rdata), .snp_we(snp_hit), .snp_idx(snp_rel[WIN_LG-1:0]),
        .snp_size(snoop_size), .snp_data(snoop_data), .bytes_flat(bytes_flat)
    );

    pfw_seq #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES),
        .BUS_BYTES(BUS_BYTES), .MAX_FETCH(MAX_FETCH)
    ) u_seq (
        .clk(clk), .rst(rst), .req(fetch_req), .req_addr(fetch_addr),
        .req_size(fetch_size), .action(action), .fill_start(fill_start),
        .flush(ctx_flush), .rd_ack(mem_rd_ack), .rd_err(mem_rd_err),
        .rd_data(mem_rdata), .bytes_flat(bytes_flat), .busy(busy),
        .rd_en(mem_rd_en), .rd_addr(mem_addr), .fill_we(fill_we),
        .fill_idx(fill_idx), .win_valid(win_valid), .win_start(win_start),
        .done(done), .bypass(bypass), .fault(fault), .data(fetch_data)
    );
endmodule

// File: rtl/pfw_check.sv
module pfw_check #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              bypass,
    input logic              fault,
    input logic              win_valid,
    input logic              ctx_flush,
    input logic              mem_rd_en,
    input logic              mem_rd_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !done && !win_valid));                    // R1
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                   // R10
    AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);                                               // R10
    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (rst)
        ctx_flush |=> !win_valid);                                         // R9
    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);                                                   // R7
    AST_FILL_FAULT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (done && fault && !bypass) |-> !win_valid);                        // R7
    AST_BYPASS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        bypass |-> done);                                                  // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && !mem_rd_ack) |=> $stable(mem_addr));                 // R6
endmodule

bind prefetch_window pfw_check #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .bypass(bypass),
    .fault(fault), .win_valid(win_valid), .ctx_flush(ctx_flush),
    .mem_rd_en(mem_rd_en), .mem_rd_ack(mem_rd_ack), .mem_addr(mem_addr)
);

// File: tb/sim_prefetch_window.sv
module sim_prefetch_window;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 16;
    localparam int PAGE = 64;
    localparam int CS   = 8;
    localparam int BUS  = 2;
    localparam int MAXF = 4;
    localparam int SZW  = $clog2(MAXF + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0, fetch_offset = '0, fetch_limit = '0;
    logic [SZW-1:0] fetch_size = SZW'(1);
    logic paging_on = 1'b0;
    logic snoop_we = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic [SZW-1:0] snoop_size = SZW'(1);
    logic [8*MAXF-1:0] snoop_data = '0;
    logic ctx_flush = 1'b0;
    logic mem_rd_en, mem_rd_ack, mem_rd_err;
    logic [AW-1:0] mem_addr;
    logic [8*BUS-1:0] mem_rdata;
    logic busy, done, bypass, fault, win_valid;
    logic [8*MAXF-1:0] fetch_data;

    logic [7:0] delta [1024];
    logic flt_en = 1'b0;
    logic [AW-1:0] flt_addr = '0;

    int checks = 0, errors = 0, cyc = 0, beats = 0;
    logic [AW-1:0] first_addr = '0;
    bit first_seen = 0, finished = 0;
    bit mv = 0; int ms = 0; bit wrote = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prefetch_window #(
        .ADDR_W(AW), .PAGE_BYTES(PAGE), .WIN_BYTES(CS), .BUS_BYTES(BUS), .MAX_FETCH(MAXF)
    ) u0 (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_offset(fetch_offset), .fetch_limit(fetch_limit), .fetch_size(fetch_size),
        .paging_on(paging_on), .snoop_we(snoop_we), .snoop_addr(snoop_addr),
        .snoop_size(snoop_size), .snoop_data(snoop_data), .ctx_flush(ctx_flush),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_rd_ack(mem_rd_ack), .mem_rd_err(mem_rd_err), .busy(busy), .done(done),
        .fetch_data(fetch_data), .bypass(bypass), .fault(fault), .win_valid(win_valid)
    );

    function automatic logic [7:0] base_byte(input logic [AW-1:0] a);
        return 8'(int'(a) * 37 + (int'(a) >> 7) + 5);
    endfunction

    function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
        return base_byte(a) ^ delta[a[9:0]];
    endfunction

    always_comb begin
        for (int j = 0; j < BUS; j++)
            mem_rdata[j*8 +: 8] = mbyte(mem_addr + AW'(j));
        mem_rd_ack = mem_rd_en;
        mem_rd_err = mem_rd_en && flt_en && ((flt_addr - mem_addr) < AW'(BUS));
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en && mem_rd_ack) begin
            beats <= beats + 1;
            if (!first_seen) begin
                first_seen <= 1;
                first_addr <= mem_addr;
            end
        end
        if (cyc >= 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: run hung, got cycle %0d exp < 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic do_snoop(input logic [AW-1:0] a, input int sz, input logic [31:0] v);
        @(negedge clk);
        snoop_we = 1; snoop_addr = a; snoop_size = SZW'(sz); snoop_data = v;
        for (int i = 0; i < sz; i++) begin
            logic [AW-1:0] b;
            b = a + AW'(i);
            delta[b[9:0]] = v[i*8 +: 8] ^ base_byte(b);
        end
        if (mv && int'(a) >= ms && int'(a) + sz <= ms + CS) wrote = 1;
        @(negedge clk);
        snoop_we = 0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        ctx_flush = 1;
        @(negedge clk);
        ctx_flush = 0;
        chk(win_valid == 0, "R9 flush", win_valid, 0);
        mv = 0;
    endtask

    task automatic run_fetch(input logic [AW-1:0] a, input logic [AW-1:0] off,
                             input logic [AW-1:0] lim, input int sz, input bit pg);
        int act, st, po, eb, lo, hi, lat;
        bit clamp, ef;
        string tg;
        logic [31:0] exp_d;
        po = int'(a) % PAGE;
        clamp = pg && (po > PAGE - CS);
        st = clamp ? (int'(a) / PAGE * PAGE + PAGE - CS) : int'(a);
        if (int'(off) + CS - 1 > int'(lim)) act = 2;
        else if (clamp && (int'(a) - st + sz) >= CS) act = 3;
        else if (mv && int'(a) >= ms && int'(a) + sz <= ms + CS) act = 0;
        else act = 1;
        eb = (act == 0) ? 0 : (act == 1) ? CS / BUS : (sz + BUS - 1) / BUS;
        lo = (act == 1) ? st : int'(a);
        hi = lo + eb * BUS - 1;
        ef = (act != 0) && flt_en && int'(flt_addr) >= lo && int'(flt_addr) <= hi;
        tg = (act == 0) ? (wrote ? "R8" : "R5") : (act == 1) ? "R6" : (act == 2) ? "R2" : "R4";
        if (act == 3) mv = 0;
        if (act == 1) begin
            if (ef) mv = 0;
            else begin mv = 1; ms = st; wrote = 0; end
        end
        exp_d = '0;
        for (int i = 0; i < sz; i++) exp_d[i*8 +: 8] = mbyte(a + AW'(i));

        @(negedge clk);
        fetch_req = 1; fetch_addr = a; fetch_offset = off; fetch_limit = lim;
        fetch_size = SZW'(sz); paging_on = pg;
        beats = 0; first_seen = 0;
        @(negedge clk);
        fetch_req = 0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(done == 1, "R10 done seen", done, 1);
        if (act == 0) chk(lat == 1, "R5 hit latency", lat, 1);
        if (!ef) chk(beats == eb, {tg, " beats"}, beats, eb);
        if (act != 0) chk(first_addr == AW'(lo), (clamp && act == 1) ? "R3 start" : {tg, " start"},
                          first_addr, lo);
        chk(fault == ef, (act == 1) ? "R7 fault" : "R12 fault", fault, ef);
        chk(bypass == (act >= 2), {tg, " bypass"}, bypass, act >= 2);
        chk(win_valid == mv, {tg, " valid"}, win_valid, mv);
        if (!ef) begin
            chk(fetch_data == exp_d, {tg, " data"}, fetch_data, exp_d);
            for (int i = sz; i < MAXF; i++)
                chk(fetch_data[i*8 +: 8] == 8'h00, "R11 zero fill", fetch_data[i*8 +: 8], 0);
        end
    endtask

    initial begin
        int n;
        for (int i = 0; i < 1024; i++) delta[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && win_valid == 0, "R1 reset",
            {busy, done, win_valid}, 0);

        n = 0;
        for (int pg = 0; pg < 2; pg++)
            for (int a = 16'h1C0; a < 16'h240; a++)
                for (int sz = 1; sz <= MAXF; sz++)
                    for (int lm = 0; lm < 2; lm++) begin
                        logic [AW-1:0] off;
                        off = AW'(a & 8'hFF);
                        n++;
                        if (n % 7 == 0)
                            do_snoop(AW'(a + 1), 2, 32'(n * 91 + 17));
                        if (n % 41 == 0)
                            do_flush();
                        run_fetch(AW'(a), off, lm ? (off + AW'(CS - 2)) : 16'hFFFF, sz, pg[0]);
                    end

        // R9: a fetch that would hit refills after a flush
        run_fetch(16'h0180, 16'h0080, 16'hFFFF, 2, 0);
        run_fetch(16'h0181, 16'h0081, 16'hFFFF, 2, 0);
        do_flush();
        run_fetch(16'h0181, 16'h0081, 16'hFFFF, 2, 0);

        // R7: refill error
        flt_en = 1; flt_addr = 16'h0105;
        run_fetch(16'h0100, 16'h0000, 16'hFFFF, 2, 0);
        // R12: direct read error keeps window
        flt_en = 0;
        run_fetch(16'h0300, 16'h0000, 16'hFFFF, 3, 0);
        flt_en = 1; flt_addr = 16'h0141;
        run_fetch(16'h0140, 16'h0040, 16'h0041, 3, 0);
        flt_en = 0;
        run_fetch(16'h0302, 16'h0002, 16'hFFFF, 4, 0);

        // R10: request raised while busy is ignored
        do_flush();
        @(negedge clk);
        fetch_req = 1; fetch_addr = 16'h01D0; fetch_offset = 16'h00D0;
        fetch_limit = 16'hFFFF; fetch_size = SZW'(2); paging_on = 0;
        @(negedge clk);
        chk(busy == 1, "R10 busy", busy, 1);
        fetch_addr = 16'h0222; fetch_size = SZW'(1);
        @(negedge clk);
        fetch_req = 0;
        n = 0;
        while (!done && n < 40) begin @(negedge clk); n++; end
        chk(fetch_data == {16'h0, mbyte(16'h01D1), mbyte(16'h01D0)}, "R10 first kept",
            fetch_data, {16'h0, mbyte(16'h01D1), mbyte(16'h01D0)});
        n = 0;
        repeat (6) begin @(negedge clk); if (done || busy) n++; end
        chk(n == 0, "R10 no second fetch", n, 0);
        mv = 1; ms = 16'h01D0;
        run_fetch(16'h01D4, 16'h00D4, 16'hFFFF, 4, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule